// File: doc/BRIEF.md
# Programmable Product-Term Array with Mode-Steered Feedback

This block is the logic core of a small programmable logic device. It has ten dedicated input pins and eight output cells. From the general-purpose pins and the cell feedback values it forms sixteen array signals. Each signal goes into a shared AND plane twice, once true and once inverted. The plane computes 64 product terms, eight for each cell. The connections are set by a fuse matrix, and a single strobe loads the whole matrix together with the operating mode.

Three operating modes decide which source reaches the eight feedback slots of the array.

- In registered mode the two special input pins (the clock pin and the enable pin) stay out of the array. Every cell feeds itself back.
- In complex mode the two special pins take the slots of the two outermost cells.
- In simple mode every slot carries the value of the neighbouring cell on the outer side, so the two centre cells drop out of the array.

The macrocells after this block receive the product terms and use them as sum terms and enable terms.

Top module: `sop_array_core`

## Requirements
- R1: After an asynchronous reset the fuse matrix is all intact (all zero) and the mode is registered, so all 64 product terms read 0 whatever the inputs are.
- R2: On a clock edge with `cfg_load_i` high, the block captures `cfg_fuse_i` and `cfg_mode_i`. At any other time the stored matrix and mode do not change, even when those ports change.
- R3: Array signal j drives line 2j in true form and line 2j+1 inverted. In a fuse row, bit l set means line l is disconnected. A product term is the AND of all the lines still connected to it.
- R4: A row with every fuse intact gives 0, because it ANDs each signal with its own inverse. A row with every fuse blown gives 1.
- R5: Array signals 0 to 7 are `pin_i[1]` to `pin_i[8]` in every mode.
- R6: Mode 0 (registered): feedback slot k (array signal 8+k) carries `fb_i[k]`, and `pin_i[0]` and `pin_i[9]` have no effect on any term.
- R7: Mode 1 (complex): slot 0 carries `pin_i[0]`, slot 7 carries `pin_i[9]`, and slots 1 to 6 carry `fb_i[1]` to `fb_i[6]`. `fb_i[0]` and `fb_i[7]` have no effect.
- R8: Mode 2 (simple): slots 0 to 3 carry `pin_i[0]`, `fb_i[0]`, `fb_i[1]`, `fb_i[2]`, and slots 4 to 7 carry `fb_i[5]`, `fb_i[6]`, `fb_i[7]`, `pin_i[9]`. `fb_i[3]` and `fb_i[4]` have no effect.
- R9: Mode 3 routes the same way as mode 0.
- R10: Fuse row r occupies `cfg_fuse_i[32r+31:32r]` and drives `pt_o[r]`. Cell c owns terms 8c to 8c+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration capture clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for the fuse matrix and the mode |
| cfg_mode_i | input | 2 | Mode: 0 registered, 1 complex, 2 simple, 3 same as 0 |
| cfg_fuse_i | input | 2048 | Fuse matrix, 64 rows of 32 bits |
| pin_i | input | 10 | Dedicated pins; bit 0 is the clock pin, bit 9 is the enable pin |
| fb_i | input | 8 | Feedback value of each cell; bit 0 is the outermost cell on one end |
| pt_o | output | 64 | Product terms, eight per cell |

## Verification
The first fuse pattern gives each of the 32 lines a row of its own. It also includes one fully intact row, one fully blown row, and a set of two-line rows. With this pattern, the walking-one feedback and pin vectors show exactly which slot each source lands on in each mode. The same vectors expose any swap between the true and inverted lines. Toggling only the sources that a mode excludes must leave every term unchanged, and this separates correct routing from routing that leaks. Random fuse matrices with random inputs in every mode check the general AND behaviour. Changing the configuration ports without the strobe shows that the stored matrix holds.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_CPX = 2'd1,
    MODE_SMP = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int FUSE_W = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FUSE_W-1:0] fuse_i,
  input  logic [1:0]        mode_i,
  output logic [FUSE_W-1:0] fuse_o,
  output sop_pkg::mode_e    mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_o <= '0;
      mode_o <= sop_pkg::MODE_REG;
    end else if (load_i) begin
      fuse_o <= fuse_i;
      mode_o <= sop_pkg::mode_e'(mode_i);
    end
  end
endmodule

// File: rtl/sop_fb_router.sv
module sop_fb_router #(
  parameter int N_CELL = 8
) (
  input  sop_pkg::mode_e    mode_i,
  input  logic              edge_lo_i,
  input  logic              edge_hi_i,
  input  logic [N_CELL-1:0] fb_i,
  output logic [N_CELL-1:0] slot_o
);
  localparam int HALF = N_CELL / 2;

  for (genvar k = 0; k < N_CELL; k++) begin : g_slot
    logic cpx_src, smp_src;
    if (k == 0) begin : g_first
      assign cpx_src = edge_lo_i;
      assign smp_src = edge_lo_i;
    end else if (k == N_CELL - 1) begin : g_last
      assign cpx_src = edge_hi_i;
      assign smp_src = edge_hi_i;
    end else if (k < HALF) begin : g_lo
      assign cpx_src = fb_i[k];
      assign smp_src = fb_i[k-1];
    end else begin : g_hi
      assign cpx_src = fb_i[k];
      assign smp_src = fb_i[k+1];
    end

    always_comb begin
      unique case (mode_i)
        sop_pkg::MODE_CPX: slot_o[k] = cpx_src;
        sop_pkg::MODE_SMP: slot_o[k] = smp_src;
        default:           slot_o[k] = fb_i[k];
      endcase
    end
  end
endmodule

// File: rtl/sop_term_array.sv
module sop_term_array #(
  parameter int N_SIG = 16,
  parameter int N_PT  = 64,
  localparam int N_LINE = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]       sig_i,
  input  logic [N_PT*N_LINE-1:0] fuse_i,
  output logic [N_PT-1:0]        pt_o
);
  logic [N_LINE-1:0] line;

  for (genvar j = 0; j < N_SIG; j++) begin : g_line
    assign line[2*j]   = sig_i[j];
    assign line[2*j+1] = ~sig_i[j];
  end

  // blown fuse (1) forces that line's contribution high
  for (genvar r = 0; r < N_PT; r++) begin : g_pt
    assign pt_o[r] = &(fuse_i[r*N_LINE +: N_LINE] | line);
  end
endmodule

// File: rtl/sop_array_core.sv
module sop_array_core #(
  parameter int N_PIN       = 10,
  parameter int N_CELL      = 8,
  parameter int PT_PER_CELL = 8,
  localparam int N_SIG  = (N_PIN - 2) + N_CELL,
  localparam int N_LINE = 2 * N_SIG,
  localparam int N_PT   = N_CELL * PT_PER_CELL,
  localparam int FUSE_W = N_PT * N_LINE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [FUSE_W-1:0] cfg_fuse_i,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic [N_CELL-1:0] fb_i,
  output logic [N_PT-1:0]   pt_o
);
  logic [FUSE_W-1:0] fuse_q;
  sop_pkg::mode_e    mode_q;
  logic [N_CELL-1:0] slot;
  logic [N_SIG-1:0]  sig;

  sop_cfg_store #(.FUSE_W(FUSE_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .fuse_i (cfg_fuse_i),
    .mode_i (cfg_mode_i),
    .fuse_o (fuse_q),
    .mode_o (mode_q)
  );

  sop_fb_router #(.N_CELL(N_CELL)) u_route (
    .mode_i    (mode_q),
    .edge_lo_i (pin_i[0]),
    .edge_hi_i (pin_i[N_PIN-1]),
    .fb_i      (fb_i),
    .slot_o    (slot)
  );

  assign sig = {slot, pin_i[N_PIN-2:1]};

  sop_term_array #(.N_SIG(N_SIG), .N_PT(N_PT)) u_arr (
    .sig_i  (sig),
    .fuse_i (fuse_q),
    .pt_o   (pt_o)
  );
endmodule

// File: rtl/sop_array_core_chk.sv
module sop_array_core_chk #(
  parameter int N_PIN  = 10,
  parameter int N_CELL = 8,
  parameter int N_PT   = 64,
  parameter int N_LINE = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_load_i,
  input logic [N_PT*N_LINE-1:0] cfg_fuse_i,
  input logic [N_PIN-1:0]       pin_i,
  input logic [N_CELL-1:0]      fb_i,
  input logic [N_PT-1:0]        pt_o,
  input logic [N_PT*N_LINE-1:0] fuse_q,
  input sop_pkg::mode_e         mode_q,
  input logic [N_CELL-1:0]      slot
);
  localparam int HALF = N_CELL / 2;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> ($stable(fuse_q) && $stable(mode_q))); // R2

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (fuse_q == $past(cfg_fuse_i))); // R2

  AST_REG_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == sop_pkg::MODE_REG) |-> (slot == fb_i)); // R6

  AST_RSV_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == sop_pkg::MODE_RSV) |-> (slot == fb_i)); // R9

  AST_CPX_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == sop_pkg::MODE_CPX) |->
      (slot[0] == pin_i[0] && slot[N_CELL-1] == pin_i[N_PIN-1])); // R7

  AST_SMP_CENTRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == sop_pkg::MODE_SMP) |->
      (slot[HALF-1] == fb_i[HALF-2] && slot[HALF] == fb_i[HALF+1])); // R8

  for (genvar r = 0; r < N_PT; r++) begin : g_row
    AST_ROW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&fuse_q[r*N_LINE +: N_LINE]) |-> pt_o[r]); // R4
    AST_ROW_INTACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_q[r*N_LINE +: N_LINE] == '0) |-> !pt_o[r]); // R4
  end
endmodule

bind sop_array_core sop_array_core_chk #(
  .N_PIN (N_PIN),
  .N_CELL(N_CELL),
  .N_PT  (N_PT),
  .N_LINE(N_LINE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .cfg_fuse_i (cfg_fuse_i),
  .pin_i      (pin_i),
  .fb_i       (fb_i),
  .pt_o       (pt_o),
  .fuse_q     (fuse_q),
  .mode_q     (mode_q),
  .slot       (slot)
);

// File: tb/sop_array_core_tb.sv
module sop_array_core_tb;
  localparam int NPT = 64;
  localparam int NL  = 32;
  localparam int FW  = NPT * NL;

  typedef struct {
    logic [NPT-1:0] exp;
    string          tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_load = 1'b0;
  logic [1:0]     cfg_mode = 2'd0;
  logic [FW-1:0]  cfg_fuse = '0;
  logic [9:0]     pin = '0;
  logic [7:0]     fb = '0;
  logic [NPT-1:0] pt;

  logic [FW-1:0]  cur_fuse = '0;
  logic [1:0]     cur_mode = 2'd0;
  item_t          sb_q[$];
  int             total = 0;
  int             bad = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  sop_array_core u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_load_i (cfg_load),
    .cfg_mode_i (cfg_mode),
    .cfg_fuse_i (cfg_fuse),
    .pin_i      (pin),
    .fb_i       (fb),
    .pt_o       (pt)
  );

  function automatic logic [NPT-1:0] model(input logic [1:0] m, input logic [9:0] p,
                                           input logic [7:0] f, input logic [FW-1:0] fz);
    logic [15:0]    s;
    logic [NL-1:0]  ln;
    logic [NPT-1:0] res;
    s[7:0] = p[8:1];                                     // R5
    case (m)
      2'd1: s[15:8] = {p[9], f[6:1], p[0]};              // R7
      2'd2: s[15:8] = {p[9], f[7], f[6], f[5], f[2], f[1], f[0], p[0]}; // R8
      default: s[15:8] = f;                              // R6, R9
    endcase
    for (int j = 0; j < 16; j++) begin
      ln[2*j]   = s[j];
      ln[2*j+1] = ~s[j];
    end
    for (int r = 0; r < NPT; r++) begin
      res[r] = 1'b1;
      for (int l = 0; l < NL; l++)
        if (!fz[r*NL+l] && !ln[l]) res[r] = 1'b0;
    end
    return res;
  endfunction

  function automatic logic [FW-1:0] pat_lines();
    logic [FW-1:0] v;
    v = '1;
    for (int r = 0; r < NPT; r++) begin
      if (r < NL) v[r*NL + r] = 1'b0;
      else if (r == 32) v[r*NL +: NL] = '0;
      else if (r == 33) v[r*NL +: NL] = '1;
      else begin
        v[r*NL + 2*((r-34)%16)]     = 1'b0;
        v[r*NL + 2*((r-33)%16) + 1] = 1'b0;
      end
    end
    return v;
  endfunction

  function automatic logic [FW-1:0] pat_rand();
    logic [FW-1:0] v;
    for (int r = 0; r < NPT; r++)
      v[r*NL +: NL] = $urandom() | $urandom() | $urandom();
    return v;
  endfunction

  task automatic load_cfg(input logic [1:0] m, input logic [FW-1:0] fz);
    @(posedge clk); #1;
    cfg_mode = m; cfg_fuse = fz; cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    cur_mode = m; cur_fuse = fz;
  endtask

  task automatic drive(input logic [9:0] p, input logic [7:0] f, input string tag);
    item_t it;
    @(posedge clk); #1;
    pin = p; fb = f;
    it.exp = model(cur_mode, p, f, cur_fuse);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (pt !== it.exp) begin
          bad++;
          $display("FAIL %s: pt=%h expected=%h", it.tag, pt, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] lines;
    lines = pat_lines();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    drive(10'h3ff, 8'hff, "R1 reset all-ones");
    drive(10'h155, 8'h5a, "R1 reset mixed");

    // R6 registered routing, R3 R4 R10 via per-line rows
    load_cfg(2'd0, lines);
    for (int k = 0; k < 8; k++) drive(10'h000, 8'(1 << k), "R6 R3 R10 walking fb");
    for (int k = 1; k < 9; k++) drive(10'(1 << k), 8'h00, "R5 walking pin");
    drive(10'h001, 8'h3c, "R6 pin0 ignored");
    drive(10'h200, 8'h3c, "R6 pin9 ignored");
    drive(10'h000, 8'h00, "R4 intact/blown rows");

    // R7 complex
    load_cfg(2'd1, lines);
    drive(10'h001, 8'h00, "R7 pin0 to slot0");
    drive(10'h200, 8'h00, "R7 pin9 to slot7");
    drive(10'h000, 8'h81, "R7 fb0 fb7 ignored");
    for (int k = 1; k < 7; k++) drive(10'h000, 8'(1 << k), "R7 walking fb");
    for (int k = 1; k < 9; k++) drive(10'(1 << k), 8'h7e, "R5 walking pin cpx");

    // R8 simple
    load_cfg(2'd2, lines);
    for (int k = 0; k < 8; k++) drive(10'h000, 8'(1 << k), "R8 walking fb");
    drive(10'h000, 8'h18, "R8 centre cells ignored");
    drive(10'h001, 8'he7, "R8 pin0 edge");
    drive(10'h200, 8'he7, "R8 pin9 edge");

    // R9 reserved mode acts as registered
    load_cfg(2'd3, lines);
    for (int k = 0; k < 8; k++) drive(10'h201, 8'(1 << k), "R9 walking fb");

    // R2 hold without load strobe
    @(posedge clk); #1;
    cfg_fuse = '0; cfg_mode = 2'd1;
    drive(10'h000, 8'hff, "R2 hold fuses");
    drive(10'h201, 8'h01, "R2 hold mode");

    // R3 random matrices in every mode
    for (int m = 0; m < 4; m++) begin
      load_cfg(2'(m), pat_rand());
      for (int n = 0; n < 6; n++)
        drive(10'($urandom()), 8'($urandom()), "R3 random");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule